// File: doc/BRIEF.md
# Serial Auto-Baud Calibration and Handshake

This block attaches to an idle-high asynchronous receive line and the matching transmit line. It lets a host pick the link rate. After reset the block waits until the line has been seen high. It then times one low interval, which the host produces by sending an all-zero byte in 8N1 format. The start bit plus eight zero data bits give a low span of nine bit times. The block divides the measured cycle count by nine, rounding to the nearest integer, and the result becomes the baud divisor. The divisor is the number of system clocks per bit, and the built-in 8N1 transmitter and receiver both use it.

With the divisor loaded, the block sends one zero byte back at the derived rate. This byte tells the host that calibration is complete. The block then listens for a single confirmation byte of 0x55. A correct confirmation with a valid stop bit gives the locked state. A wrong value, a bad stop bit, a low interval too long for the counter, or a low interval so short that the divisor rounds to zero gives the failed state. Both outcomes are final. Only a reset starts a new measurement.

The counter width is a parameter. At its default of 16 bits it covers nine bit times at 2400 bit/s with a 16 MHz clock. The system must run at no less than 8, 4 or 2 MHz for host rates of 9600, 4800 or 2400 bit/s respectively.

Top module: `autobaud_link`

## Requirements
- R1: Both directions use 8N1 frames. A frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts `divisor` clock cycles.
- R2: The receive input passes through a two-flop synchronizer whose reset value is low. Measurement starts only at the first falling edge after the line has been seen high, so a line held low out of reset is not measured.
- R3: If the receive line is low for L clock cycles, `divisor` becomes floor((L + 4) / 9). Before the measurement completes, `divisor` is zero.
- R4: Once a nonzero divisor is set, the block transmits exactly one 0x00 byte. `tx_out` is low for exactly 9 × `divisor` cycles and then high.
- R5: After the 0x00 byte has been sent, reception of 0x55 with a high stop bit sets `locked` to 1 and `busy` to 0. `divisor` does not change after that.
- R6: A received confirmation byte other than 0x55 sets `error` to 1 and `locked` stays 0.
- R7: A confirmation byte whose stop bit is sampled low sets `error` to 1, even if its data is 0x55.
- R8: A low interval of 2^CNT_W or more cycles sets `error`, and no byte is transmitted. A low interval of 2^CNT_W − 1 cycles is accepted.
- R9: A low interval shorter than 5 cycles rounds to a divisor of zero. It sets `error`, `divisor` stays 0, and no byte is transmitted. An interval of 5 cycles gives a divisor of 1.
- R10: `error` and `locked` each hold until reset. After a failure, further receive-line activity is ignored: `tx_out` stays high and `divisor` does not change.
- R11: After reset, `tx_out` = 1, `divisor` = 0, `locked` = 0, `error` = 0 and `busy` = 1. `busy` equals NOT(`locked` OR `error`) at all times, and `locked` and `error` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| tx_out | output | 1 | Serial transmit line, idle high |
| divisor | output | CNT_W | Derived clocks-per-bit value |
| locked | output | 1 | Handshake completed successfully |
| error | output | 1 | Calibration or handshake failed |
| busy | output | 1 | Calibration or handshake still in progress |

## Verification
The bench builds the block with an 8-bit counter instead of the default 16 bits. The counter ceiling of 255 cycles therefore lies near bit periods of only a few clocks, so both sides of the overflow boundary (255 and 256 cycles) can be reached in a short run. It also uses a 28-clock bit period that completes a full handshake at the largest divisor the narrow counter allows. Periods of 8 and 9 clocks put the rounding boundary (76 versus 77 cycles) and the zero-divisor boundary (4 versus 5 cycles) within a few hundred cycles.

// File: rtl/abd_pkg.sv
package abd_pkg;
  localparam logic [7:0] ACK_BYTE     = 8'h00;
  localparam logic [7:0] CONFIRM_BYTE = 8'h55;
  localparam int         CAL_BITS     = 9;
  localparam int         FRAME_BITS   = 10;

  typedef enum logic [2:0] {C_MEAS, C_TX, C_RX, C_LOCK, C_FAIL} ctl_t;
  typedef enum logic [2:0] {M_ARM, M_WAIT, M_COUNT, M_DIV, M_DONE, M_OVF} meter_t;
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rxst_t;
endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {STAGES{RST_VAL}};
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/abd_meter.sv
module abd_meter
  import abd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_s,
  output logic [CNT_W-1:0] quo_o,
  output logic             done_o,
  output logic             ovf_o
);
  localparam logic [CNT_W:0] DIVK  = (CNT_W+1)'(CAL_BITS);
  localparam logic [CNT_W:0] ROUND = (CNT_W+1)'(CAL_BITS / 2);

  meter_t           st;
  logic             prev;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   rem;
  logic [CNT_W-1:0] quo;
  logic             fall;

  assign fall = prev & ~rx_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= M_ARM;
      prev   <= 1'b0;
      cnt    <= '0;
      rem    <= '0;
      quo    <= '0;
      done_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      prev   <= rx_s;
      done_o <= 1'b0;
      ovf_o  <= 1'b0;
      case (st)
        M_ARM:   if (rx_s) st <= M_WAIT;
        M_WAIT:  if (fall) begin
                   cnt <= CNT_W'(1);
                   st  <= M_COUNT;
                 end
        M_COUNT: begin
          if (!rx_s) begin
            if (cnt == '1) begin
              st    <= M_OVF;
              ovf_o <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            rem <= {1'b0, cnt} + ROUND;
            quo <= '0;
            st  <= M_DIV;
          end
        end
        M_DIV: begin
          if (rem >= DIVK) begin
            rem <= rem - DIVK;
            quo <= quo + 1'b1;
          end else begin
            st     <= M_DONE;
            done_o <= 1'b1;
          end
        end
        default: st <= st;
      endcase
    end
  end

  assign quo_o = quo;

  // R8
  count_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
    (st == M_COUNT) |-> (cnt != '0));
endmodule

// File: rtl/abd_tx.sv
module abd_tx
  import abd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [7:0]       data_i,
  input  logic [CNT_W-1:0] div_i,
  output logic             line_o,
  output logic             done_o
);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sh;
  logic [BIT_W-1:0]      bit_q;
  logic [CNT_W-1:0]      cnt;
  logic                  act;

  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= 1'b0;
      line_o <= 1'b1;
      sh     <= '1;
      bit_q  <= '0;
      cnt    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!act) begin
        if (start_i) begin
          sh     <= {1'b1, data_i, 1'b0};
          act    <= 1'b1;
          line_o <= 1'b0;
          cnt    <= '0;
          bit_q  <= '0;
        end
      end else if (cnt == div_i - 1'b1) begin
        cnt <= '0;
        if (bit_q == LAST_BIT) begin
          act    <= 1'b0;
          line_o <= 1'b1;
          done_o <= 1'b1;
        end else begin
          bit_q  <= bit_q + 1'b1;
          sh     <= {1'b1, sh[FRAME_BITS-1:1]};
          line_o <= sh[1];
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !act |-> line_o);
endmodule

// File: rtl/abd_rx.sv
module abd_rx
  import abd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             rx_s,
  input  logic [CNT_W-1:0] div_i,
  output logic [7:0]       data_o,
  output logic             valid_o,
  output logic             ferr_o
);
  rxst_t            st;
  logic             prev;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bit_q;
  logic [7:0]       sh;
  logic [CNT_W-1:0] half;

  assign half = div_i >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= R_IDLE;
      prev    <= 1'b0;
      cnt     <= '0;
      bit_q   <= '0;
      sh      <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      prev    <= rx_s;
      valid_o <= 1'b0;
      case (st)
        R_IDLE: if (en_i && prev && !rx_s) begin
                  cnt <= '0;
                  st  <= R_START;
                end
        R_START: begin
          if (cnt == half) begin
            cnt   <= '0;
            bit_q <= '0;
            st    <= rx_s ? R_IDLE : R_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        R_DATA: begin
          if (cnt == div_i - 1'b1) begin
            cnt <= '0;
            sh  <= {rx_s, sh[7:1]};
            if (bit_q == 3'd7) st <= R_STOP;
            else               bit_q <= bit_q + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == div_i - 1'b1) begin
            cnt     <= '0;
            data_o  <= sh;
            ferr_o  <= ~rx_s;
            valid_o <= 1'b1;
            st      <= R_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R5
  rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
endmodule

// File: rtl/autobaud_link.sv
module autobaud_link
  import abd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_in,
  output logic             tx_out,
  output logic [CNT_W-1:0] divisor,
  output logic             locked,
  output logic             error,
  output logic             busy
);
  ctl_t             st;
  logic             rx_s;
  logic [CNT_W-1:0] m_quo;
  logic             m_done, m_ovf;
  logic             tx_go, tx_done;
  logic [7:0]       rx_data;
  logic             rx_valid, rx_ferr;
  logic             rx_en;

  assign rx_en = (st == C_RX);

  abd_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst(rst), .d(rx_in), .q(rx_s));

  abd_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst(rst), .rx_s(rx_s),
    .quo_o(m_quo), .done_o(m_done), .ovf_o(m_ovf));

  abd_tx #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .start_i(tx_go), .data_i(ACK_BYTE),
    .div_i(divisor), .line_o(tx_out), .done_o(tx_done));

  abd_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .en_i(rx_en), .rx_s(rx_s), .div_i(divisor),
    .data_o(rx_data), .valid_o(rx_valid), .ferr_o(rx_ferr));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= C_MEAS;
      divisor <= '0;
      tx_go   <= 1'b0;
      locked  <= 1'b0;
      error   <= 1'b0;
      busy    <= 1'b1;
    end else begin
      tx_go <= 1'b0;
      case (st)
        C_MEAS: begin
          if (m_ovf) begin
            st    <= C_FAIL;
            error <= 1'b1;
            busy  <= 1'b0;
          end else if (m_done) begin
            divisor <= m_quo;
            if (m_quo == '0) begin
              st    <= C_FAIL;
              error <= 1'b1;
              busy  <= 1'b0;
            end else begin
              tx_go <= 1'b1;
              st    <= C_TX;
            end
          end
        end
        C_TX: if (tx_done) st <= C_RX;
        C_RX: begin
          if (rx_valid) begin
            busy <= 1'b0;
            if (!rx_ferr && rx_data == CONFIRM_BYTE) begin
              st     <= C_LOCK;
              locked <= 1'b1;
            end else begin
              st    <= C_FAIL;
              error <= 1'b1;
            end
          end
        end
        default: st <= st;
      endcase
    end
  end

  // R11
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(locked && error));
  // R10
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    error |=> (error && $stable(divisor)));
  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> (locked && $stable(divisor)));
  // R4
  tx_needs_div_chk: assert property (@(posedge clk) disable iff (rst)
    tx_go |-> (divisor != '0));
endmodule

// File: tb/sim_autobaud_link.sv
module sim_autobaud_link;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rx_in = 1'b1;
  logic         tx_out, locked, error, busy;
  logic [W-1:0] divisor;

  int  vectors = 0;
  int  miscompares = 0;
  int  model_div = -1;
  int  model_outcome = 0;
  bit  mon_en = 1'b0;
  bit  done_flag = 1'b0;
  int  cyc = 0;
  int  run;

  always #10 clk = ~clk;

  autobaud_link #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .rx_in(rx_in), .tx_out(tx_out),
    .divisor(divisor), .locked(locked), .error(error), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // reference model compared on every clock
  always @(negedge clk) begin
    if (mon_en) begin
      chk(busy == !(locked || error), "R11", int'(busy), int'(!(locked || error)));
      chk(!(locked && error), "R11", int'(locked && error), 0);
      if (model_div >= 0) chk(int'(divisor) == model_div, "R3", int'(divisor), model_div);
      if (model_outcome == 1) chk(locked && !error, "R5", int'(locked), 1);
      if (model_outcome == 2) begin
        chk(error && !locked, "R10", int'(error), 1);
        chk(tx_out == 1'b1, "R10", int'(tx_out), 1);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic level);
    mon_en = 1'b0;
    model_div = -1;
    model_outcome = 0;
    rst = 1'b1;
    rx_in = level;
    idle(4);
    rst = 1'b0;
    mon_en = 1'b1;
  endtask

  task automatic send_low(input int len);
    @(negedge clk) rx_in = 1'b0;
    repeat (len) @(negedge clk);
    rx_in = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, input int p, input logic stop);
    @(negedge clk) rx_in = 1'b0;
    repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_in = b[i];
      repeat (p) @(negedge clk);
    end
    rx_in = stop;
    repeat (p) @(negedge clk);
    rx_in = 1'b1;
  endtask

  task automatic tx_lowrun(output int r);
    int t;
    t = 0;
    r = -1;
    while (tx_out == 1'b1 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 3000) return;
    r = 0;
    while (tx_out == 1'b0 && r < 5000) begin
      @(negedge clk);
      r++;
    end
  endtask

  initial begin
    // R11 reset state
    do_reset(1'b1);
    @(negedge clk);
    chk(tx_out == 1'b1, "R11", int'(tx_out), 1);
    chk(divisor == '0, "R11", int'(divisor), 0);
    chk(!locked && !error, "R11", int'(locked || error), 0);
    chk(busy == 1'b1, "R11", int'(busy), 1);

    // R1/R3/R4/R5: 8-clock bit period, full handshake
    idle(20);
    send_low(72);
    tx_lowrun(run);
    chk(run == 72, "R4", run, 72);
    chk(divisor == 8'd8, "R3", int'(divisor), 8);
    model_div = 8;
    idle(14);
    send_byte(8'h55, 8, 1'b1);
    idle(20);
    chk(locked == 1'b1, "R1", int'(locked), 1);
    chk(busy == 1'b0 && error == 1'b0, "R5", int'(busy), 0);
    model_outcome = 1;
    idle(40);

    // R3 rounding boundary
    do_reset(1'b1);
    idle(20);
    send_low(76);
    tx_lowrun(run);
    chk(divisor == 8'd8, "R3", int'(divisor), 8);
    chk(run == 72, "R4", run, 72);
    do_reset(1'b1);
    idle(20);
    send_low(77);
    tx_lowrun(run);
    chk(divisor == 8'd9, "R3", int'(divisor), 9);
    chk(run == 81, "R4", run, 81);

    // R6 wrong confirmation, then R10 later activity ignored
    do_reset(1'b1);
    idle(20);
    send_low(72);
    tx_lowrun(run);
    model_div = 8;
    idle(14);
    send_byte(8'hAA, 8, 1'b1);
    idle(20);
    chk(error == 1'b1 && locked == 1'b0, "R6", int'(error), 1);
    model_outcome = 2;
    idle(20);
    send_low(72);
    idle(200);
    chk(error == 1'b1 && tx_out == 1'b1, "R10", int'(error && tx_out), 1);
    chk(divisor == 8'd8, "R10", int'(divisor), 8);

    // R7 framing error on confirmation
    do_reset(1'b1);
    idle(20);
    send_low(72);
    tx_lowrun(run);
    idle(14);
    send_byte(8'h55, 8, 1'b0);
    idle(20);
    chk(error == 1'b1 && locked == 1'b0, "R7", int'(error), 1);

    // R8 largest countable interval is accepted
    do_reset(1'b1);
    idle(20);
    send_low(255);
    tx_lowrun(run);
    chk(divisor == 8'd28, "R8", int'(divisor), 28);
    chk(run == 252, "R8", run, 252);
    model_div = 28;
    idle(34);
    send_byte(8'h55, 28, 1'b1);
    idle(40);
    chk(locked == 1'b1, "R8", int'(locked), 1);

    // R8 one more cycle overflows
    do_reset(1'b1);
    idle(20);
    send_low(256);
    idle(100);
    chk(error == 1'b1, "R8", int'(error), 1);
    chk(divisor == '0, "R8", int'(divisor), 0);
    model_outcome = 2;
    idle(50);

    // R9 zero-divisor boundary
    do_reset(1'b1);
    idle(20);
    send_low(4);
    idle(30);
    chk(error == 1'b1, "R9", int'(error), 1);
    chk(divisor == '0, "R9", int'(divisor), 0);
    model_outcome = 2;
    idle(20);
    do_reset(1'b1);
    idle(20);
    send_low(5);
    idle(10);
    chk(divisor == 8'd1 && error == 1'b0, "R9", int'(divisor), 1);

    // R2 line held low out of reset is not measured
    do_reset(1'b0);
    idle(40);
    rx_in = 1'b1;
    idle(20);
    send_low(72);
    tx_lowrun(run);
    chk(run == 72, "R2", run, 72);
    chk(divisor == 8'd8, "R2", int'(divisor), 8);

    mon_en = 1'b0;
    finish_run();
  end
endmodule